// File: doc/BRIEF.md
# Masked CAN Identifier Acceptance Filter

This block decides what happens to a CAN frame once its identifier has arrived. It holds no storage of its own: a bank of message objects (15 by default) is presented on configuration ports, each object carrying an identifier, a format bit (standard or extended), a direction bit and a valid bit. Alongside them sit a short global mask for standard identifiers, a long global mask for extended identifiers, and a last-object mask that only the final object uses.

When a request strobe arrives with the frame's identifier, its extended-format flag and its remote flag, the block compares the identifier against every object in parallel. One clock later it presents the index of the winning object and an action code: store the frame, answer it with a transmit reply, or ignore it. The final object is a catch-all receive buffer. It compares under the global mask ANDed with the last-object mask and only wins when no other object matches. Frame reception, bit timing, CRC and the data memory sit outside this block.

Top module: `acf_filter`

## Requirements
- R1: While reset is held and after it is released with no request, res_vld_o is 0, res_idx_o is 0 and res_act_o is 0 (ignore).
- R2: res_vld_o is high exactly in the cycle after a cycle with rx_vld_i high. res_idx_o and res_act_o keep their values through cycles without a request.
- R3: A mask bit of 0 makes that identifier bit a don't care. A standard frame compares identifier bits [10:0] under the 11-bit short global mask. An extended frame compares all 29 bits under the 29-bit long global mask.
- R4: An object whose valid bit is 0 never matches. An object matches only if its format bit equals the frame's extended flag.
- R5: Among matching objects the lowest index wins. Object k is reported as res_idx_o = k (1..15), bit k-1 of each per-object vector. With no match res_idx_o = 0 and the action is ignore.
- R6: Action codes are 0 = ignore, 1 = store, 2 = reply. A winning receive object (direction 0) returns store for a data frame and ignore for a remote frame.
- R7: A winning transmit object (direction 1) returns reply for a remote frame and ignore for a data frame.
- R8: The last object compares under the global mask ANDed with the last-object mask (low 11 bits for standard frames). It wins only when no lower object matches.
- R9: The last object's direction selects the frame type it takes: direction 0 stores data frames, direction 1 stores remote frames. The other type returns ignore. It never returns reply.
- R10: With the last-object mask all zero, the last object takes every identifier of its format that no other object takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld_i | input | 1 | Request strobe for one frame identifier |
| rx_id_i | input | 29 | Frame identifier (standard uses bits [10:0]) |
| rx_ext_i | input | 1 | 1 = extended-format frame |
| rx_rtr_i | input | 1 | 1 = remote frame, 0 = data frame |
| gmask_std_i | input | 11 | Short global mask |
| gmask_ext_i | input | 29 | Long global mask |
| lmask_i | input | 29 | Last-object mask |
| obj_id_i | input | 435 | Object identifiers, object k at bits [(k-1)*29 +: 29] |
| obj_ext_i | input | 15 | Object format bits |
| obj_dir_i | input | 15 | Object direction bits, 1 = transmit |
| obj_val_i | input | 15 | Object valid bits |
| res_vld_o | output | 1 | Result valid |
| res_idx_o | output | 4 | Winning object index, 0 = none |
| res_act_o | output | 2 | Action: 0 ignore, 1 store, 2 reply |

## Verification
The hardest outcome to reach from the ports is a catch-all win under a partial last-object mask. It needs all lower objects to miss while the last object hits only through bits that the combined mask releases. Purely random identifiers almost never hit any object. The stimulus therefore derives most identifiers from a chosen object's identifier, flips only bits that the relevant mask clears, and sometimes invalidates or reformats lower objects. Directed cases add duplicate objects for the priority check and an all-zero last-object mask.

// File: rtl/acf_pkg.sv
package acf_pkg;
  typedef enum logic [1:0] {
    ACT_IGNORE = 2'd0,
    ACT_STORE  = 2'd1,
    ACT_REPLY  = 2'd2
  } acf_act_e;
endpackage

// File: rtl/acf_obj_cmp.sv
module acf_obj_cmp #(
  parameter int IDW  = 29,
  parameter int SIDW = 11
) (
  input  logic [IDW-1:0]  id_i,
  input  logic            ext_i,
  input  logic [IDW-1:0]  obj_id_i,
  input  logic            obj_ext_i,
  input  logic            obj_val_i,
  input  logic [SIDW-1:0] mask_std_i,
  input  logic [IDW-1:0]  mask_ext_i,
  output logic            hit_o
);
  logic [IDW-1:0]  diff_ext;
  logic [SIDW-1:0] diff_std;
  logic            id_eq;

  always_comb begin
    diff_ext = (id_i ^ obj_id_i) & mask_ext_i;
    diff_std = (id_i[SIDW-1:0] ^ obj_id_i[SIDW-1:0]) & mask_std_i;
    id_eq    = ext_i ? (diff_ext == '0) : (diff_std == '0);
    hit_o    = obj_val_i && (obj_ext_i == ext_i) && id_eq;
  end
endmodule

// File: rtl/acf_prio_enc.sv
module acf_prio_enc #(
  parameter int N  = 15,
  localparam int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i + 1);
    end
  end
endmodule

// File: rtl/acf_filter.sv
module acf_filter
  import acf_pkg::*;
#(
  parameter int NOBJ = 15,
  parameter int IDW  = 29,
  parameter int SIDW = 11,
  localparam int IW  = $clog2(NOBJ + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_vld_i,
  input  logic [IDW-1:0]      rx_id_i,
  input  logic                rx_ext_i,
  input  logic                rx_rtr_i,
  input  logic [SIDW-1:0]     gmask_std_i,
  input  logic [IDW-1:0]      gmask_ext_i,
  input  logic [IDW-1:0]      lmask_i,
  input  logic [NOBJ*IDW-1:0] obj_id_i,
  input  logic [NOBJ-1:0]     obj_ext_i,
  input  logic [NOBJ-1:0]     obj_dir_i,
  input  logic [NOBJ-1:0]     obj_val_i,
  output logic                res_vld_o,
  output logic [IW-1:0]       res_idx_o,
  output logic [1:0]          res_act_o
);
  logic [NOBJ-1:0] hit;
  logic [IW-1:0]   win_idx;
  logic            win_dir;
  acf_act_e        act_d;
  logic [IW-1:0]   idx_q;
  acf_act_e        act_q;
  logic            vld_q;

  // comparators: regular objects use the global masks, last one the combined mask
  for (genvar g = 0; g < NOBJ; g++) begin : g_obj
    if (g == NOBJ - 1) begin : g_last
      acf_obj_cmp #(.IDW(IDW), .SIDW(SIDW)) u_cmp (
        .id_i       (rx_id_i),
        .ext_i      (rx_ext_i),
        .obj_id_i   (obj_id_i[g*IDW +: IDW]),
        .obj_ext_i  (obj_ext_i[g]),
        .obj_val_i  (obj_val_i[g]),
        .mask_std_i (gmask_std_i & lmask_i[SIDW-1:0]),
        .mask_ext_i (gmask_ext_i & lmask_i),
        .hit_o      (hit[g])
      );
    end else begin : g_reg
      acf_obj_cmp #(.IDW(IDW), .SIDW(SIDW)) u_cmp (
        .id_i       (rx_id_i),
        .ext_i      (rx_ext_i),
        .obj_id_i   (obj_id_i[g*IDW +: IDW]),
        .obj_ext_i  (obj_ext_i[g]),
        .obj_val_i  (obj_val_i[g]),
        .mask_std_i (gmask_std_i),
        .mask_ext_i (gmask_ext_i),
        .hit_o      (hit[g])
      );
    end
  end

  // lowest index wins; the catch-all sits at the top so it only wins alone
  acf_prio_enc #(.N(NOBJ)) u_prio (
    .req_i (hit),
    .idx_o (win_idx)
  );

  always_comb begin
    win_dir = 1'b0;
    for (int i = 0; i < NOBJ; i++) begin
      if (win_idx == IW'(i + 1)) win_dir = obj_dir_i[i];
    end
    act_d = ACT_IGNORE;
    if (win_idx == IW'(NOBJ)) begin
      if (win_dir == rx_rtr_i) act_d = ACT_STORE;
    end else if (win_idx != '0) begin
      if (!win_dir && !rx_rtr_i)     act_d = ACT_STORE;
      else if (win_dir && rx_rtr_i)  act_d = ACT_REPLY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
      act_q <= ACT_IGNORE;
    end else begin
      vld_q <= rx_vld_i;
      if (rx_vld_i) begin
        idx_q <= win_idx;
        act_q <= act_d;
      end
    end
  end

  assign res_vld_o = vld_q;
  assign res_idx_o = idx_q;
  assign res_act_o = act_q;

  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld_i |=> res_vld_o);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld_i |=> (!res_vld_o && $stable(res_idx_o) && $stable(res_act_o)));
  a_r5_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_idx_o == '0) |-> res_act_o == ACT_IGNORE);
  a_r7_reply_needs_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld_i && !rx_rtr_i) |=> res_act_o != ACT_REPLY);
  a_r9_catchall_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_idx_o == IW'(NOBJ)) |-> res_act_o != ACT_REPLY);
endmodule

// File: tb/sim_acf_filter.sv
module sim_acf_filter;
  localparam int NOBJ = 15;
  localparam int IDW  = 29;
  localparam int SIDW = 11;
  localparam int IW   = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                rx_vld_i = 1'b0;
  logic [IDW-1:0]      rx_id_i = '0;
  logic                rx_ext_i = 1'b0;
  logic                rx_rtr_i = 1'b0;
  logic [SIDW-1:0]     gmask_std_i = '1;
  logic [IDW-1:0]      gmask_ext_i = '1;
  logic [IDW-1:0]      lmask_i = '1;
  logic [NOBJ*IDW-1:0] obj_id_i = '0;
  logic [NOBJ-1:0]     obj_ext_i = '0;
  logic [NOBJ-1:0]     obj_dir_i = '0;
  logic [NOBJ-1:0]     obj_val_i = '0;
  logic                res_vld_o;
  logic [IW-1:0]       res_idx_o;
  logic [1:0]          res_act_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  acf_filter u0 (.*);

  function automatic bit exp_hit(int k, logic [IDW-1:0] id, logic ext);
    logic [IDW-1:0]  me;
    logic [SIDW-1:0] ms;
    logic [IDW-1:0]  oid;
    oid = obj_id_i[k*IDW +: IDW];
    me  = gmask_ext_i;
    ms  = gmask_std_i;
    if (k == NOBJ - 1) begin
      me = me & lmask_i;
      ms = ms & lmask_i[SIDW-1:0];
    end
    if (!obj_val_i[k] || obj_ext_i[k] != ext) return 1'b0;
    if (ext) return ((id ^ oid) & me) == '0;
    return ((id[SIDW-1:0] ^ oid[SIDW-1:0]) & ms) == '0;
  endfunction

  function automatic void exp_res(output int idx, output int act);
    idx = 0;
    act = 0;
    for (int k = 0; k < NOBJ; k++) begin
      if (idx == 0 && exp_hit(k, rx_id_i, rx_ext_i)) idx = k + 1;
    end
    if (idx == NOBJ) act = (obj_dir_i[NOBJ-1] == rx_rtr_i) ? 1 : 0;
    else if (idx != 0) begin
      if (!obj_dir_i[idx-1] && !rx_rtr_i) act = 1;
      else if (obj_dir_i[idx-1] && rx_rtr_i) act = 2;
    end
  endfunction

  task automatic check(string req, int got_idx, int got_act, int e_idx, int e_act);
    checks++;
    if (got_idx != e_idx || got_act != e_act) begin
      fails++;
      $display("FAIL %s idx/act actual=%0d/%0d expected=%0d/%0d", req, got_idx, got_act, e_idx, e_act);
    end
  endtask

  // one request: drive at negedge, result registered at next posedge, sample at next negedge
  task automatic frame(string req, logic [IDW-1:0] id, logic ext, logic rtr, int want_idx = -1);
    int ei, ea;
    rx_vld_i = 1'b1; rx_id_i = id; rx_ext_i = ext; rx_rtr_i = rtr;
    exp_res(ei, ea);
    if (want_idx >= 0 && want_idx != ei) begin
      checks++; fails++;
      $display("FAIL %s scenario actual=%0d expected=%0d", req, ei, want_idx);
    end
    @(negedge clk);
    rx_vld_i = 1'b0;
    checks++;
    if (res_vld_o !== 1'b1) begin
      fails++;
      $display("FAIL R2 res_vld actual=%b expected=1", res_vld_o);
    end
    check(req, res_idx_o, res_act_o, ei, ea);
  endtask

  function automatic void set_obj(int k, logic [IDW-1:0] id, logic ext, logic dir, logic val);
    obj_id_i[k*IDW +: IDW] = id;
    obj_ext_i[k] = ext;
    obj_dir_i[k] = dir;
    obj_val_i[k] = val;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ei, ea;
    logic [IDW-1:0] id;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 during reset", res_idx_o, res_act_o, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (res_vld_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 res_vld actual=%b expected=0", res_vld_o);
    end
    check("R1 after reset", res_idx_o, res_act_o, 0, 0);

    // R4: nothing valid -> index 0, ignore (R5)
    frame("R4 R5 none valid", 29'h5A, 1'b0, 1'b0, 0);

    // R6 receive object, standard data frame and remote frame
    set_obj(2, 29'h123, 1'b0, 1'b0, 1'b1);
    frame("R6 rx data", 29'h123, 1'b0, 1'b0, 3);
    frame("R6 rx remote ignored", 29'h123, 1'b0, 1'b1, 3);
    // R4 format mismatch
    frame("R4 ext mismatch", 29'h123, 1'b1, 1'b0, 0);
    // R3 standard compares only low 11 bits
    frame("R3 upper bits ignored std", 29'h1FFF_F923, 1'b0, 1'b0, 3);
    // R3 masked bit don't care
    gmask_std_i = 11'h7FE;
    frame("R3 mask dont care", 29'h122, 1'b0, 1'b0, 3);
    gmask_std_i = '1;
    frame("R3 unmasked mismatch", 29'h122, 1'b0, 1'b0, 0);
    // R7 transmit object
    set_obj(5, 29'h0ABC_DEF, 1'b1, 1'b1, 1'b1);
    frame("R7 tx remote reply", 29'h0ABC_DEF, 1'b1, 1'b1, 6);
    frame("R7 tx data ignored", 29'h0ABC_DEF, 1'b1, 1'b0, 6);
    gmask_ext_i = 29'h1FFF_FF00;
    frame("R3 ext mask", 29'h0ABC_D00, 1'b1, 1'b1, 6);
    gmask_ext_i = '1;
    // R5 priority: duplicate lower object wins
    set_obj(1, 29'h123, 1'b0, 1'b1, 1'b1);
    frame("R5 lowest wins", 29'h123, 1'b0, 1'b1, 2);
    // R2 hold during idle
    @(negedge clk);
    checks++;
    if (res_vld_o !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle vld actual=%b expected=0", res_vld_o);
    end
    check("R2 hold idle", res_idx_o, res_act_o, 2, 2);
    // R4 valid cleared
    obj_val_i[1] = 1'b0;
    frame("R4 invalid skipped", 29'h123, 1'b0, 1'b0, 3);
    // R10 catch-all with zero last mask
    set_obj(NOBJ-1, 29'h000, 1'b0, 1'b0, 1'b1);
    lmask_i = '0;
    frame("R10 catch-all any id", 29'h3C5, 1'b0, 1'b0, NOBJ);
    frame("R8 lower still wins", 29'h123, 1'b0, 1'b0, 3);
    frame("R9 dir0 remote ignored", 29'h3C5, 1'b0, 1'b1, NOBJ);
    obj_dir_i[NOBJ-1] = 1'b1;
    frame("R9 dir1 remote stored", 29'h3C5, 1'b0, 1'b1, NOBJ);
    frame("R9 dir1 data ignored", 29'h3C5, 1'b0, 1'b0, NOBJ);
    // R8 partial last mask: combined mask limits the catch-all
    obj_dir_i[NOBJ-1] = 1'b0;
    lmask_i = 29'h700;
    gmask_std_i = 11'h3FF;
    frame("R8 combined mask hit", 29'h4FF, 1'b0, 1'b0, NOBJ);
    frame("R8 combined mask miss", 29'h2FF, 1'b0, 1'b0, 0);
    gmask_std_i = '1;
    lmask_i = '1;

    // constrained random
    for (int t = 0; t < 400; t++) begin
      for (int k = 0; k < NOBJ; k++) begin
        set_obj(k, IDW'($urandom), 1'($urandom), 1'($urandom),
                ($urandom_range(9) < 7));
      end
      gmask_std_i = ($urandom_range(3) == 0) ? SIDW'($urandom) : '1;
      gmask_ext_i = ($urandom_range(3) == 0) ? IDW'($urandom) : '1;
      lmask_i     = ($urandom_range(2) == 0) ? '0 : IDW'($urandom);
      if ($urandom_range(3) == 0) obj_val_i[NOBJ-2:0] = '0;
      begin
        int k = $urandom_range(NOBJ - 1);
        logic ext = obj_ext_i[k];
        id = obj_id_i[k*IDW +: IDW];
        if ($urandom_range(4) == 0) id = IDW'($urandom);
        else id = id ^ (IDW'($urandom) & ~(ext ? gmask_ext_i & lmask_i : {18'h0, gmask_std_i & lmask_i[SIDW-1:0]}));
        frame("R5 R6 R7 R8 random", id, ext, 1'($urandom));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule